// File: doc/BRIEF.md
# Pipeline Exception Redirect and Squash Controller

This block sits beside a five-stage in-order pipeline (fetch, decode, execute, memory access, write-back). It handles faults that are found in the stage that owns them, not at one commit point. The execute stage may report that a taken branch has an illegal target. The memory stage may report that a load has an illegal data address. In the same cycle that a fault is reported, the block does three things:

- It steers the next-PC multiplexer to a handler address. Each fault kind has its own handler address, fixed when the design is built.
- It raises per-stage squash lines. These turn the faulting instruction, and every younger instruction already in flight, into bubbles.
- It latches the PC of the faulting instruction and a cause code. Both become visible one cycle later.

Fetch picks up the first handler instruction in the next cycle. When both stages report a fault in the same cycle, the memory-stage fault belongs to the older instruction and wins.

The block has no data stream, so it has no valid/ready handshake. All pins are plain control and status lines. Every decision is combinational on the stage inputs. Only the saved PC and the cause are registered.

Top module: `exc_flush_ctrl`

## Requirements
- R1: After reset, `epc` is 0, `cause` is 0, `pc_sel` is 0 and `flush` is 0.
- R2: While neither stage has a valid fault, `pc_sel` is 0 (sequential fetch), `redirect_pc` is 0 and `flush` is 4'b0000.
- R3: A valid execute-stage fault (`ex_valid` and `ex_bad_target`), with no memory-stage fault, drives `pc_sel` = 1 and `redirect_pc` = `BTGT_HANDLER` in the same cycle.
- R4: In the R3 case, `flush` is 4'b0111. Bit 0 is fetch, bit 1 is decode, bit 2 is execute (the faulting instruction itself) and bit 3 is memory access, which stays clear.
- R5: A valid memory-stage fault (`mem_valid` and `mem_bad_addr`) drives `pc_sel` = 2, `redirect_pc` = `DADDR_HANDLER` and `flush` = 4'b1111 in the same cycle.
- R6: When both stages report valid faults in the same cycle, the memory-stage fault is taken: the outputs are those of R5, and `epc` and `cause` record the memory-stage instruction.
- R7: A fault flag whose stage valid is low is ignored. It changes neither the same-cycle outputs nor `epc` or `cause`.
- R8: One cycle after a taken fault, `epc` holds that instruction's PC and `cause` holds 1 for a bad branch target or 2 for a bad data address.
- R9: `epc` and `cause` keep their values in every cycle with no taken fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ex_valid | input | 1 | Execute stage holds a live instruction |
| ex_bad_target | input | 1 | Execute stage branch target is illegal |
| ex_pc | input | XLEN | PC of the execute-stage instruction |
| mem_valid | input | 1 | Memory stage holds a live instruction |
| mem_bad_addr | input | 1 | Memory stage data address is illegal |
| mem_pc | input | XLEN | PC of the memory-stage instruction |
| pc_sel | output | 2 | Next-PC select: 0 sequential, 1 branch-target handler, 2 data-address handler |
| redirect_pc | output | XLEN | Handler address for the selected fault, 0 when none |
| flush | output | 4 | Squash per stage, bit 0 fetch up to bit 3 memory access |
| epc | output | XLEN | PC of the last taken faulting instruction |
| cause | output | 2 | Code of the last taken fault |

## Verification
The hardest case to reach is two faults in the same cycle. An older load faults in the memory stage while the branch behind it faults in execute. A wrong design could then record the younger PC or spare the execute-stage instruction from the squash. The driver raises both flags in one cycle with different PCs, and then checks the next cycle to confirm that `epc` names the load. Separate steps drive flags with their stage valid low, and then check the next cycle to confirm that the recorded state did not move.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int NSTG = 4;
  localparam int STG_IF  = 0;
  localparam int STG_ID  = 1;
  localparam int STG_EX  = 2;
  localparam int STG_MEM = 3;
  localparam int NSRC = 2;
  localparam int SRC_EX  = 0;
  localparam int SRC_MEM = 1;

  typedef enum logic [1:0] {
    SEL_SEQ   = 2'd0,
    SEL_BTGT  = 2'd1,
    SEL_DADDR = 2'd2
  } pcsel_e;

  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'd0,
    CAUSE_BTGT  = 2'd1,
    CAUSE_DADDR = 2'd2
  } cause_e;
endpackage

// File: rtl/exc_detect.sv
module exc_detect
  import exc_pkg::*;
(
  input  logic [NSRC-1:0] stg_valid,
  input  logic [NSRC-1:0] stg_flag,
  output logic [NSRC-1:0] hit
);
  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign hit[i] = stg_valid[i] & stg_flag[i];
  end
endmodule

// File: rtl/exc_prio.sv
module exc_prio
  import exc_pkg::*;
(
  input  logic [NSRC-1:0] hit,
  output pcsel_e          sel,
  output cause_e          code,
  output logic            taken,
  output logic [NSTG-1:0] flush
);
  int unsigned fault_stg;

  always_comb begin
    sel       = SEL_SEQ;
    code      = CAUSE_NONE;
    fault_stg = 0;
    if (hit[SRC_MEM]) begin
      sel       = SEL_DADDR;
      code      = CAUSE_DADDR;
      fault_stg = STG_MEM;
    end else if (hit[SRC_EX]) begin
      sel       = SEL_BTGT;
      code      = CAUSE_BTGT;
      fault_stg = STG_EX;
    end
  end

  assign taken = |hit;

  for (genvar s = 0; s < NSTG; s++) begin : g_flush
    assign flush[s] = taken && (s <= fault_stg);
  end
endmodule

// File: rtl/exc_record.sv
module exc_record
  import exc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [XLEN-1:0] pc_in,
  input  cause_e          code_in,
  output logic [XLEN-1:0] epc,
  output logic [1:0]      cause
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      epc   <= '0;
      cause <= CAUSE_NONE;
    end else if (load) begin
      epc   <= pc_in;
      cause <= code_in;
    end
  end

  assert_epc_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (epc == $past(pc_in) && cause == $past(code_in)));
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(epc) && $stable(cause)));
  assert_cause_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cause));
endmodule

// File: rtl/exc_flush_ctrl.sv
module exc_flush_ctrl
  import exc_pkg::*;
#(
  parameter int              XLEN          = 32,
  parameter logic [XLEN-1:0] BTGT_HANDLER  = 32'h0000_0180,
  parameter logic [XLEN-1:0] DADDR_HANDLER = 32'h0000_01C0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ex_valid,
  input  logic            ex_bad_target,
  input  logic [XLEN-1:0] ex_pc,
  input  logic            mem_valid,
  input  logic            mem_bad_addr,
  input  logic [XLEN-1:0] mem_pc,
  output logic [1:0]      pc_sel,
  output logic [XLEN-1:0] redirect_pc,
  output logic [3:0]      flush,
  output logic [XLEN-1:0] epc,
  output logic [1:0]      cause
);
  logic [NSRC-1:0] hit;
  pcsel_e          sel;
  cause_e          code;
  logic            taken;
  logic [XLEN-1:0] fault_pc;

  exc_detect u_det (
    .stg_valid ({mem_valid, ex_valid}),
    .stg_flag  ({mem_bad_addr, ex_bad_target}),
    .hit       (hit)
  );

  exc_prio u_prio (
    .hit   (hit),
    .sel   (sel),
    .code  (code),
    .taken (taken),
    .flush (flush)
  );

  always_comb begin
    unique case (sel)
      SEL_BTGT:  redirect_pc = BTGT_HANDLER;
      SEL_DADDR: redirect_pc = DADDR_HANDLER;
      default:   redirect_pc = '0;
    endcase
  end

  assign pc_sel   = sel;
  assign fault_pc = (sel == SEL_DADDR) ? mem_pc : ex_pc;

  exc_record #(.XLEN(XLEN)) u_rec (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (taken),
    .pc_in   (fault_pc),
    .code_in (code),
    .epc     (epc),
    .cause   (cause)
  );

  assert_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(ex_valid && ex_bad_target) && !(mem_valid && mem_bad_addr)
      |-> (flush == 4'b0000 && pc_sel == 2'd0));
  assert_ex_redirect_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid && ex_bad_target && !(mem_valid && mem_bad_addr))
      |-> (flush == 4'b0111 && pc_sel == 2'd1 && redirect_pc == BTGT_HANDLER));
  assert_mem_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_bad_addr)
      |-> (flush == 4'b1111 && pc_sel == 2'd2 && redirect_pc == DADDR_HANDLER));
  assert_mem_epc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_bad_addr) |=> (epc == $past(mem_pc) && cause == 2'd2));
endmodule

// File: tb/test_exc_flush_ctrl.sv
module test_exc_flush_ctrl;
  localparam int PER = 10;
  localparam logic [31:0] H_BT = 32'h0000_0180;
  localparam logic [31:0] H_DA = 32'h0000_01C0;

  typedef struct {
    string       tag;
    logic [1:0]  sel;
    logic [31:0] rd;
    logic [3:0]  fl;
    logic [31:0] epc;
    logic [1:0]  cause;
  } exp_t;

  logic clk = 0, rst_n = 0;
  logic ex_valid = 0, ex_bad_target = 0, mem_valid = 0, mem_bad_addr = 0;
  logic [31:0] ex_pc = 0, mem_pc = 0;
  logic [1:0] pc_sel, cause;
  logic [31:0] redirect_pc, epc;
  logic [3:0] flush;

  int total = 0, bad = 0;
  exp_t q[$];
  event smp_ev;
  logic [31:0] m_epc = 0;
  logic [1:0] m_cause = 0;

  always #(PER/2) clk = ~clk;

  exc_flush_ctrl i_exc_flush_ctrl (
    .clk(clk), .rst_n(rst_n),
    .ex_valid(ex_valid), .ex_bad_target(ex_bad_target), .ex_pc(ex_pc),
    .mem_valid(mem_valid), .mem_bad_addr(mem_bad_addr), .mem_pc(mem_pc),
    .pc_sel(pc_sel), .redirect_pc(redirect_pc), .flush(flush),
    .epc(epc), .cause(cause)
  );

  function automatic void chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endfunction

  task automatic drive(string tag, bit ev, bit eb, logic [31:0] ep,
                       bit mv, bit mb, logic [31:0] mp);
    exp_t e;
    bit eh, mh;
    @(negedge clk);
    ex_valid = ev; ex_bad_target = eb; ex_pc = ep;
    mem_valid = mv; mem_bad_addr = mb; mem_pc = mp;
    eh = ev && eb;
    mh = mv && mb;
    e.tag = tag;
    e.epc = m_epc;
    e.cause = m_cause;
    if (mh) begin
      e.sel = 2; e.rd = H_DA; e.fl = 4'b1111;
      m_epc = mp; m_cause = 2;
    end else if (eh) begin
      e.sel = 1; e.rd = H_BT; e.fl = 4'b0111;
      m_epc = ep; m_cause = 1;
    end else begin
      e.sel = 0; e.rd = 0; e.fl = 4'b0000;
    end
    q.push_back(e);
    #(PER/4);
    -> smp_ev;
  endtask

  initial begin : monitor
    forever begin
      exp_t e;
      @(smp_ev);
      e = q.pop_front();
      chk(e.tag, "pc_sel", {30'd0, pc_sel}, {30'd0, e.sel});
      chk(e.tag, "redirect_pc", redirect_pc, e.rd);
      chk(e.tag, "flush", {28'd0, flush}, {28'd0, e.fl});
      chk(e.tag, "epc", epc, e.epc);
      chk(e.tag, "cause", {30'd0, cause}, {30'd0, e.cause});
    end
  end

  initial begin : watchdog
    #(PER * 20000);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "epc in reset", epc, 0);
    chk("R1", "cause in reset", {30'd0, cause}, 0);
    @(negedge clk);
    rst_n = 1;
    drive("R1", 0, 0, 0, 0, 0, 0);
    drive("R2", 1, 0, 32'h40, 1, 0, 32'h3C);
    drive("R3_R4", 1, 1, 32'h100, 0, 0, 0);
    drive("R8", 0, 0, 0, 0, 0, 0);
    drive("R9", 1, 0, 32'h108, 1, 0, 32'h104);
    drive("R5", 1, 0, 32'h208, 1, 1, 32'h204);
    drive("R8", 0, 0, 0, 0, 0, 0);
    drive("R6", 1, 1, 32'h300, 1, 1, 32'h2FC);
    drive("R6", 0, 0, 0, 0, 0, 0);
    drive("R7", 0, 1, 32'h500, 0, 1, 32'h4FC);
    drive("R7", 0, 1, 32'h504, 0, 0, 0);
    drive("R7", 0, 0, 0, 0, 1, 32'h600);
    drive("R9", 0, 0, 0, 0, 0, 0);
    drive("R3", 1, 1, 32'h700, 0, 1, 32'h6FC);
    drive("R5", 0, 0, 0, 1, 1, 32'h800);
    drive("R8", 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule